// File: doc/BRIEF.md
# Rotating-Parity Stripe Controller

This block sits between a block-level command source and five independent disk ports, each modelled as a simple synchronous memory indexed by stripe. A logical block number is split into a stripe index and a slot inside the stripe. Each stripe carries four data blocks and one parity block, and the parity position steps down by one disk from stripe to stripe. The controller turns each logical command into the smallest set of per-disk reads and writes that keeps every stripe's parity consistent.

A write touches only the target data disk and the stripe's parity disk. It reads the old data and the old parity, then writes the new data and a parity equal to the old parity XOR the old data XOR the new data. A single failed disk can be flagged with each command. Reads that land on the failed disk are rebuilt from the four surviving blocks. A write whose data disk has failed folds the new data into parity only. A write whose parity disk has failed stores the data alone. Commands are handled one at a time: `busy` holds off new commands, and `done` marks the end of each operation.

Top module: `psc_stripe_ctrl`

## Requirements
- R1: Logical block `lba` lives in stripe `lba / 4`, and that stripe keeps its parity on disk `4 - (stripe mod 5)`. For example, stripes 0 and 5 use disk 4 and stripe 3 uses disk 1.
- R2: The slot `lba mod 4` maps to a data disk in ascending order, skipping the parity disk. The disk is equal to the slot when the slot is below the parity disk, and to slot + 1 otherwise.
- R3: After any sequence of writes on a healthy array, the parity block of every stripe equals the XOR of its four data blocks.
- R4: A read whose target disk has not failed strobes a read on that disk only. It returns the stored block on `rd_data`, with `done` high in the third cycle after the accepting clock edge.
- R5: A write on a healthy stripe strobes reads on exactly the target and parity disks in one cycle. It strobes writes on exactly those two disks in a later cycle, with `done` high in the fourth cycle after acceptance.
- R6: A read of a block on the failed disk strobes reads on the other four disks. It returns their XOR, which equals the last value written to that block, with `done` in the third cycle.
- R7: A write whose data disk has failed reads the three surviving data disks and writes the parity disk only. The new parity is the XOR of the new data and those three blocks. A later rebuilt read returns the new data. `done` is high in the fourth cycle.
- R8: A write whose parity disk has failed issues no reads and writes the data disk only, with `done` in the second cycle after acceptance.
- R9: `busy` is high from the cycle after acceptance through the `done` cycle. A `cmd_valid` raised while `busy` is high is ignored and causes no disk access.
- R10: `done` lasts one cycle per operation. A disk flagged as failed is never strobed.
- R11: After reset and while idle, `busy`, `done` and all disk strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present; accepted when not busy |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_lba | input | LBA_W | Logical block number |
| cmd_wdata | input | BLK_W | Block to write |
| fail_en | input | 1 | One disk is flagged as failed for this command |
| fail_id | input | $clog2(NDISK) | Index of the failed disk |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| rd_data | output | BLK_W | Read result, valid when done follows a read |
| dsk_addr | output | LBA_W | Stripe index presented to all disks |
| dsk_rd | output | NDISK | Per-disk read strobe |
| dsk_wr | output | NDISK | Per-disk write strobe |
| dsk_wdata | output | NDISK*BLK_W | Per-disk write block, disk d at bits d*BLK_W |
| dsk_rdata | input | NDISK*BLK_W | Per-disk read block, valid the cycle after its read strobe |

## Verification
The bench builds the controller with five disks, 16-bit blocks and a 6-bit block number. This gives sixteen stripes, so the parity rotation wraps through stripes 5, 10 and 15 and both ends of the address range can be reached. The narrow blocks keep the bench's disk memories and XOR references small. The 64-block space still lets one failed disk land, in different stripes, on a data slot and on a parity slot. This covers the direct-read, rebuild, parity-only and data-only paths.

// File: rtl/psc_pkg.sv
package psc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_EVAL,
        ST_STORE,
        ST_DONE
    } seq_state_e;

    typedef enum logic [2:0] {
        OP_RD_DIRECT,
        OP_RD_REBUILD,
        OP_WR_RMW,
        OP_WR_PARITY,
        OP_WR_DATA
    } op_kind_e;

    // Choose the access pattern from the command and where the failure sits.
    function automatic op_kind_e classify_op(input logic is_write,
                                             input logic hits_target,
                                             input logic hits_parity);
        op_kind_e k;
        if (!is_write)
            k = hits_target ? OP_RD_REBUILD : OP_RD_DIRECT;
        else if (hits_target)
            k = OP_WR_PARITY;
        else if (hits_parity)
            k = OP_WR_DATA;
        else
            k = OP_WR_RMW;
        return k;
    endfunction

    function automatic logic op_skips_fetch(input op_kind_e k);
        return k == OP_WR_DATA;
    endfunction

    function automatic logic op_is_read(input op_kind_e k);
        return (k == OP_RD_DIRECT) || (k == OP_RD_REBUILD);
    endfunction

endpackage

// File: rtl/psc_stripe_map.sv
module psc_stripe_map #(
    parameter int NDISK = 5,
    parameter int LBA_W = 8,
    parameter int DW    = 3
) (
    input  logic [LBA_W-1:0] lba,
    output logic [LBA_W-1:0] stripe,
    output logic [DW-1:0]    par_disk,
    output logic [DW-1:0]    dat_disk
);
    localparam int NDATA = NDISK - 1;

    logic [LBA_W-1:0] slot;
    logic [LBA_W-1:0] turn;

    always_comb begin
        stripe   = lba / LBA_W'(NDATA);
        slot     = lba % LBA_W'(NDATA);
        turn     = stripe % LBA_W'(NDISK);
        par_disk = DW'(NDISK - 1) - DW'(turn);
        if (DW'(slot) < par_disk)
            dat_disk = DW'(slot);
        else
            dat_disk = DW'(slot) + DW'(1);
    end

endmodule

// File: rtl/psc_masked_xor.sv
module psc_masked_xor #(
    parameter int NDISK = 5,
    parameter int BLK_W = 32
) (
    input  logic [NDISK*BLK_W-1:0] blocks,
    input  logic [NDISK-1:0]       sel,
    input  logic [BLK_W-1:0]       seed,
    output logic [BLK_W-1:0]       result
);
    always_comb begin
        result = seed;
        for (int d = 0; d < NDISK; d++) begin
            if (sel[d])
                result = result ^ blocks[d*BLK_W +: BLK_W];
        end
    end
endmodule

// File: rtl/psc_stripe_ctrl.sv
module psc_stripe_ctrl
    import psc_pkg::*;
#(
    parameter int NDISK = 5,
    parameter int BLK_W = 32,
    parameter int LBA_W = 8,
    localparam int DW   = $clog2(NDISK)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cmd_valid,
    input  logic                   cmd_write,
    input  logic [LBA_W-1:0]       cmd_lba,
    input  logic [BLK_W-1:0]       cmd_wdata,
    input  logic                   fail_en,
    input  logic [DW-1:0]          fail_id,
    output logic                   busy,
    output logic                   done,
    output logic [BLK_W-1:0]       rd_data,
    output logic [LBA_W-1:0]       dsk_addr,
    output logic [NDISK-1:0]       dsk_rd,
    output logic [NDISK-1:0]       dsk_wr,
    output logic [NDISK*BLK_W-1:0] dsk_wdata,
    input  logic [NDISK*BLK_W-1:0] dsk_rdata
);
    seq_state_e       state_q;
    op_kind_e         op_q;
    op_kind_e         op_next;
    logic             accept;

    logic [LBA_W-1:0] map_stripe;
    logic [DW-1:0]    map_par;
    logic [DW-1:0]    map_dat;

    logic [LBA_W-1:0] stripe_q;
    logic [DW-1:0]    tgt_q;
    logic [DW-1:0]    par_q;
    logic [DW-1:0]    fail_q;
    logic             fail_en_q;
    logic [BLK_W-1:0] wdata_q;
    logic [BLK_W-1:0] newpar_q;
    logic [BLK_W-1:0] rd_data_q;

    logic [NDISK-1:0] tgt_bit;
    logic [NDISK-1:0] par_bit;
    logic [NDISK-1:0] fail_bit;
    logic [NDISK-1:0] fetch_mask;
    logic [NDISK-1:0] store_mask;

    logic [BLK_W-1:0] fold_seed;
    logic [BLK_W-1:0] fold_out;

    psc_stripe_map #(
        .NDISK (NDISK),
        .LBA_W (LBA_W),
        .DW    (DW)
    ) u_map (
        .lba      (cmd_lba),
        .stripe   (map_stripe),
        .par_disk (map_par),
        .dat_disk (map_dat)
    );

    assign accept  = (state_q == ST_IDLE) && cmd_valid;
    assign op_next = classify_op(cmd_write,
                                 fail_en && (fail_id == map_dat),
                                 fail_en && (fail_id == map_par));

    assign tgt_bit  = NDISK'(1) << tgt_q;
    assign par_bit  = NDISK'(1) << par_q;
    assign fail_bit = fail_en_q ? (NDISK'(1) << fail_q) : '0;

    // Which disks are read, and which are written, for each kind of operation.
    always_comb begin
        fetch_mask = '0;
        store_mask = '0;
        unique case (op_q)
            OP_RD_DIRECT:  fetch_mask = tgt_bit;
            OP_RD_REBUILD: fetch_mask = ~fail_bit;
            OP_WR_RMW: begin
                fetch_mask = tgt_bit | par_bit;
                store_mask = tgt_bit | par_bit;
            end
            OP_WR_PARITY: begin
                fetch_mask = ~fail_bit & ~par_bit;
                store_mask = par_bit;
            end
            OP_WR_DATA:    store_mask = tgt_bit;
            default: begin
                fetch_mask = '0;
                store_mask = '0;
            end
        endcase
    end

    assign fold_seed = op_is_read(op_q) ? '0 : wdata_q;

    psc_masked_xor #(
        .NDISK (NDISK),
        .BLK_W (BLK_W)
    ) u_fold (
        .blocks (dsk_rdata),
        .sel    (fetch_mask),
        .seed   (fold_seed),
        .result (fold_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            op_q      <= OP_RD_DIRECT;
            stripe_q  <= '0;
            tgt_q     <= '0;
            par_q     <= '0;
            fail_q    <= '0;
            fail_en_q <= 1'b0;
            wdata_q   <= '0;
            newpar_q  <= '0;
            rd_data_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        op_q      <= op_next;
                        stripe_q  <= map_stripe;
                        tgt_q     <= map_dat;
                        par_q     <= map_par;
                        fail_q    <= fail_id;
                        fail_en_q <= fail_en;
                        wdata_q   <= cmd_wdata;
                        state_q   <= op_skips_fetch(op_next) ? ST_STORE : ST_FETCH;
                    end
                end
                ST_FETCH: state_q <= ST_EVAL;
                ST_EVAL: begin
                    if (op_is_read(op_q)) begin
                        rd_data_q <= fold_out;
                        state_q   <= ST_DONE;
                    end else begin
                        newpar_q  <= fold_out;
                        state_q   <= ST_STORE;
                    end
                end
                ST_STORE: state_q <= ST_DONE;
                ST_DONE:  state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (state_q != ST_IDLE);
    assign done     = (state_q == ST_DONE);
    assign rd_data  = rd_data_q;
    assign dsk_addr = stripe_q;

    for (genvar d = 0; d < NDISK; d++) begin : g_port
        assign dsk_rd[d] = (state_q == ST_FETCH) && fetch_mask[d];
        assign dsk_wr[d] = (state_q == ST_STORE) && store_mask[d];
        assign dsk_wdata[d*BLK_W +: BLK_W] = par_bit[d] ? newpar_q : wdata_q;
    end

endmodule

// File: rtl/psc_checker.sv
module psc_checker #(
    parameter int NDISK = 5,
    parameter int DW    = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             done,
    input logic             cmd_valid,
    input logic [NDISK-1:0] dsk_rd,
    input logic [NDISK-1:0] dsk_wr,
    input logic             fail_seen,
    input logic [DW-1:0]    fail_which
);
    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r9_done_while_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    a_r9_start_needs_cmd: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(cmd_valid));

    a_r5_two_disk_store: assert property (@(posedge clk) disable iff (rst)
        $countones(dsk_wr) <= 2);

    a_r10_failed_quiet: assert property (@(posedge clk) disable iff (rst)
        (busy && fail_seen) |-> (((dsk_rd | dsk_wr) & (NDISK'(1) << fail_which)) == '0));

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> ((dsk_rd == '0) && (dsk_wr == '0)));

    a_r11_no_rw_clash: assert property (@(posedge clk) disable iff (rst)
        (dsk_rd & dsk_wr) == '0);
endmodule

bind psc_stripe_ctrl psc_checker #(
    .NDISK (NDISK),
    .DW    (DW)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .done       (done),
    .cmd_valid  (cmd_valid),
    .dsk_rd     (dsk_rd),
    .dsk_wr     (dsk_wr),
    .fail_seen  (fail_en_q),
    .fail_which (fail_q)
);

// File: tb/tb_psc_stripe_ctrl.sv
module tb_psc_stripe_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NDISK = 5;
    localparam int BLK_W = 16;
    localparam int LBA_W = 6;
    localparam int DW    = $clog2(NDISK);
    localparam int NDATA = NDISK - 1;
    localparam int NLBA  = 1 << LBA_W;
    localparam int NSTR  = NLBA / NDATA;

    logic                   clk = 1'b0;
    logic                   rst;
    logic                   cmd_valid, cmd_write, fail_en;
    logic [LBA_W-1:0]       cmd_lba;
    logic [BLK_W-1:0]       cmd_wdata;
    logic [DW-1:0]          fail_id;
    logic                   busy, done;
    logic [BLK_W-1:0]       rd_data;
    logic [LBA_W-1:0]       dsk_addr;
    logic [NDISK-1:0]       dsk_rd, dsk_wr;
    logic [NDISK*BLK_W-1:0] dsk_wdata;
    logic [NDISK*BLK_W-1:0] dsk_rdata;

    int checks = 0;
    int errors = 0;

    logic [BLK_W-1:0] mem    [NDISK][NSTR];
    logic [BLK_W-1:0] shadow [NLBA];

    always #(CLK_PERIOD/2) clk = ~clk;

    psc_stripe_ctrl #(.NDISK(NDISK), .BLK_W(BLK_W), .LBA_W(LBA_W)) dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_lba(cmd_lba), .cmd_wdata(cmd_wdata), .fail_en(fail_en), .fail_id(fail_id),
        .busy(busy), .done(done), .rd_data(rd_data), .dsk_addr(dsk_addr),
        .dsk_rd(dsk_rd), .dsk_wr(dsk_wr), .dsk_wdata(dsk_wdata), .dsk_rdata(dsk_rdata)
    );

    // Memory-modelled disks: one-cycle read latency, write at the strobe edge.
    always @(posedge clk) begin
        for (int d = 0; d < NDISK; d++) begin
            if (dsk_rd[d]) dsk_rdata[d*BLK_W +: BLK_W] <= mem[d][dsk_addr];
            if (dsk_wr[d]) mem[d][dsk_addr] <= dsk_wdata[d*BLK_W +: BLK_W];
        end
    end

    function automatic int par_of(input int s);
        return NDISK - 1 - (s % NDISK);
    endfunction

    function automatic int disk_of(input int lba);
        int s = lba / NDATA;
        int i = lba % NDATA;
        return (i < par_of(s)) ? i : i + 1;
    endfunction

    function automatic logic [BLK_W-1:0] stripe_parity(input int s);
        logic [BLK_W-1:0] x = '0;
        for (int i = 0; i < NDATA; i++) x = x ^ shadow[s*NDATA + i];
        return x;
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Compare every surviving disk of a stripe against the logical view.
    task automatic check_stripe(input int s, input bit fen, input int fid);
        int p = par_of(s);
        for (int d = 0; d < NDISK; d++) begin
            if (fen && d == fid) continue;
            if (d == p)
                check("R3", $sformatf("parity stripe %0d disk %0d", s, d), 32'(mem[d][s]), 32'(stripe_parity(s)));
            else
                check("R2", $sformatf("placement stripe %0d disk %0d", s, d), 32'(mem[d][s]),
                      32'(shadow[s*NDATA + ((d < p) ? d : d - 1)]));
        end
    endtask

    task automatic run_op(input bit wr, input int lba, input logic [BLK_W-1:0] data,
                          input bit fen, input int fid, input bit inject, input string req);
        int s = lba / NDATA;
        int p = par_of(s);
        int t = disk_of(lba);
        int lat;
        logic [NDISK-1:0] exp_rd, exp_wr, seen_rd, seen_wr, fb;
        logic [BLK_W-1:0] exp_data;
        fb = fen ? NDISK'(1 << fid) : '0;
        exp_data = shadow[lba];
        if (!wr) begin
            lat = 3; exp_wr = '0;
            exp_rd = (fen && fid == t) ? ~fb : NDISK'(1 << t);
        end else if (fen && fid == t) begin
            lat = 4; exp_rd = ~fb & ~NDISK'(1 << p); exp_wr = NDISK'(1 << p);
        end else if (fen && fid == p) begin
            lat = 2; exp_rd = '0; exp_wr = NDISK'(1 << t);
        end else begin
            lat = 4; exp_rd = NDISK'((1 << t) | (1 << p)); exp_wr = exp_rd;
        end
        seen_rd = '0; seen_wr = '0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_write = wr; cmd_lba = LBA_W'(lba); cmd_wdata = data;
        fail_en = fen; fail_id = DW'(fid);
        for (int n = 1; n <= lat + 1; n++) begin
            @(negedge clk);
            if (n == 1) cmd_valid = 1'b0;
            if (inject && n == 2) begin
                cmd_valid = 1'b1; cmd_write = 1'b1; cmd_lba = LBA_W'(9); cmd_wdata = 16'hDEAD;
            end
            if (inject && n == 3) cmd_valid = 1'b0;
            check("R9", $sformatf("busy cycle %0d lba %0d", n, lba), 32'(busy), 32'(n <= lat));
            check("R10", $sformatf("done cycle %0d lba %0d", n, lba), 32'(done), 32'(n == lat));
            seen_rd = seen_rd | dsk_rd;
            seen_wr = seen_wr | dsk_wr;
            if (!wr && n == lat)
                check(req, $sformatf("read data lba %0d", lba), 32'(rd_data), 32'(exp_data));
        end
        check(req, $sformatf("read strobes lba %0d", lba), 32'(seen_rd), 32'(exp_rd));
        check(req, $sformatf("write strobes lba %0d", lba), 32'(seen_wr), 32'(exp_wr));
        if (wr) shadow[lba] = data;
    endtask

    initial begin
        for (int l = 0; l < NLBA; l++) shadow[l] = BLK_W'(16'hA5C3 ^ (l * 16'h0123));
        for (int s = 0; s < NSTR; s++) begin
            for (int i = 0; i < NDATA; i++) mem[disk_of(s*NDATA + i)][s] = shadow[s*NDATA + i];
            mem[par_of(s)][s] = stripe_parity(s);
        end
        dsk_rdata = '0;
        rst = 1'b1; cmd_valid = 1'b0; cmd_write = 1'b0; cmd_lba = '0; cmd_wdata = '0;
        fail_en = 1'b0; fail_id = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check("R11", "busy after reset", 32'(busy), 32'd0);
        check("R11", "done after reset", 32'(done), 32'd0);
        check("R11", "strobes after reset", 32'({dsk_rd, dsk_wr}), 32'd0);

        // R1 R2 R4: healthy reads across the rotation, including wrap at stripe 5.
        run_op(0, 0, '0, 0, 0, 0, "R4");
        run_op(0, 5, '0, 0, 0, 0, "R1");
        run_op(0, 22, '0, 0, 0, 0, "R1");
        run_op(0, 63, '0, 0, 0, 0, "R2");
        check_stripe(1, 0, 0);
        check_stripe(5, 0, 0);

        // R5 R3: small writes, then stripe consistency and read-back.
        run_op(1, 5, 16'h1234, 0, 0, 0, "R5");
        run_op(1, 20, 16'hBEEF, 0, 0, 0, "R5");
        run_op(1, 13, 16'h0F0F, 0, 0, 0, "R5");
        run_op(1, 63, 16'hFFFF, 0, 0, 0, "R5");
        run_op(1, 4, 16'h5555, 0, 0, 0, "R5");
        check_stripe(1, 0, 0);
        check_stripe(3, 0, 0);
        check_stripe(5, 0, 0);
        check_stripe(15, 0, 0);
        run_op(0, 5, '0, 0, 0, 0, "R3");
        run_op(0, 20, '0, 0, 0, 0, "R3");

        // R9: a command raised while busy is dropped.
        run_op(0, 7, '0, 0, 0, 1, "R9");
        run_op(0, 9, '0, 0, 0, 0, "R9");
        check_stripe(2, 0, 0);

        // R6: degraded reads with disk 2 failed.
        run_op(0, 2, '0, 1, 2, 0, "R6");
        run_op(0, 0, '0, 1, 2, 0, "R4");
        run_op(0, 13, '0, 1, 2, 0, "R6");

        // R7: write to the failed data disk updates parity only.
        run_op(1, 2, 16'hC0DE, 1, 2, 0, "R7");
        check("R7", "failed disk untouched", 32'(mem[2][0]), 32'(16'hA5C3 ^ 16'h0246));
        check_stripe(0, 1, 2);
        run_op(0, 2, '0, 1, 2, 0, "R7");

        // R8: stripe 2 keeps parity on disk 2, which has failed.
        run_op(1, 8, 16'h7777, 1, 2, 0, "R8");
        check("R8", "data disk written", 32'(mem[0][2]), 32'h7777);
        run_op(0, 8, '0, 1, 2, 0, "R8");
        run_op(1, 1, 16'h2468, 1, 4, 0, "R8");
        check("R8", "data disk stripe0", 32'(mem[1][0]), 32'h2468);

        $display("%0d/%0d checks passed", checks - errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R9 watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", checks - errors, checks);
        $finish;
    end
endmodule